// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt request pulses from peripherals into a latched status register and gates them with a mask register. It drives a single level-sensitive interrupt line to the processor. That line is high whenever some status bit is both pending and enabled. Request input bit `i` sets status bit `i`. By system convention, bit 3 carries the DMA engine's request, bit 7 the serial port's request and bit 9 the sound unit's request.

Software reaches both registers through a small register bus that supports 16-bit and 32-bit accesses. To acknowledge a source, software writes a 0 to its status bit. Writing a 1 leaves that bit as it was. Any status write also discards every pending bit that the mask does not currently enable. A mask write stores the new enables. When the write leaves a pending bit enabled, the block raises a one-cycle check pulse at once, so the processor side can re-examine its interrupt state without waiting for the registered line.

Top module: `irq_stat_ctrl`

## Requirements
- R1: Reset clears the status and mask registers and drives `irqOut` and `checkPulse` low.
- R2: A 1 on `reqIn[i]` at a rising clock edge sets status bit `i`. A set bit stays set until a status write clears it.
- R3: A write to the status register (offset 0x070) loads status AND mask AND write data. A data bit of 0 clears that bit, a data bit of 1 keeps it, and bits not enabled in the mask are dropped.
- R4: A request that arrives in the same cycle as a status write is merged into status first, and the acknowledge is applied to the merged value.
- R5: A write to the mask register (offset 0x074) stores the written data as the new mask. The mask is unchanged in every other cycle.
- R6: A 16-bit write (`busWide`=0) changes only bits 15:0 of the addressed register. A 32-bit write (`busWide`=1) changes all 32 bits.
- R7: `irqOut` is the OR of (status AND mask), registered. It reflects the register state of the previous cycle.
- R8: `checkPulse` is high for exactly the one cycle after a mask write, and only when the status and mask held after that write share a set bit.
- R9: `busRdData` returns status at 0x070 and mask at 0x074. A 32-bit read returns all 32 bits, and a 16-bit read returns bits 15:0 zero-extended. Any other offset reads 0.
- R10: Writes to offsets other than 0x070 and 0x074 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Register byte offset within the I/O page |
| busWrEn | input | 1 | Write strobe for this cycle |
| busWide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| reqIn | input | 32 | Peripheral request pulses, one per status bit |
| irqOut | output | 1 | Level interrupt line to the processor |
| checkPulse | output | 1 | One-cycle pending check after a mask write |

## Verification
The bench targets the following corner cases:
- **Request colliding with an acknowledge.** A design that applies the acknowledge before merging the request would leave a stale bit set or lose a fresh request.
- **Status write against a partial mask.** A design that ignores the mask on acknowledge would keep disabled bits pending.
- **16-bit writes.** A design without lane gating would wipe the upper half of the register.
- **Latency of `irqOut` and `checkPulse`.** These are sampled in the exact cycle each should change. An off-by-one register would show up as an early or late edge. A check pulse raised against the old mask would fire when the new enables leave nothing pending.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic statWr;
    logic maskWr;
    logic loLane;
    logic hiLane;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2
  } rdSel_t;
endpackage

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int STAT_OFS = 'h070,
  parameter int MASK_OFS = 'h074
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busWide,
  output wrStrobe_t         strb,
  output rdSel_t            rdSel,
  output logic              rdWide
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  logic hitStat;
  logic hitMask;

  assign hitStat = (busAddr == STAT_A);
  assign hitMask = (busAddr == MASK_A);

  always_comb begin
    strb.statWr = busWrEn & hitStat;
    strb.maskWr = busWrEn & hitMask;
    strb.loLane = busWrEn & (hitStat | hitMask);
    strb.hiLane = busWrEn & (hitStat | hitMask) & busWide;
  end

  always_comb begin
    if (hitStat)      rdSel = RD_STAT;
    else if (hitMask) rdSel = RD_MASK;
    else              rdSel = RD_NONE;
  end

  assign rdWide = busWide;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.statWr, strb.maskWr})); // R10
  AST_LANE_LO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr || strb.maskWr) |-> strb.loLane); // R6
  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn) |-> (!strb.statWr && !strb.maskWr)); // R10
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strb,
  input  rdSel_t           rdSel,
  input  logic             rdWide,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] reqIn,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             chkPulse
);
  logic [REG_W-1:0] statQ;
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] statNext;
  logic [REG_W-1:0] maskNext;
  logic [REG_W-1:0] rdWord;
  logic             irqQ;
  logic             chkQ;

  for (genvar b = 0; b < REG_W; b++) begin : gBit
    logic laneHit;
    logic setVal;
    if (b < HALF_W) begin : gLo
      assign laneHit = strb.loLane;
    end else begin : gHi
      assign laneHit = strb.hiLane;
    end
    assign setVal      = statQ[b] | reqIn[b];
    assign statNext[b] = (strb.statWr && laneHit) ? (setVal & maskQ[b] & wrData[b]) : setVal;
    assign maskNext[b] = (strb.maskWr && laneHit) ? wrData[b] : maskQ[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      maskQ <= '0;
      irqQ  <= 1'b0;
      chkQ  <= 1'b0;
    end else begin
      statQ <= statNext;
      maskQ <= maskNext;
      irqQ  <= |(statQ & maskQ);
      chkQ  <= strb.maskWr & (|(statNext & maskNext));
    end
  end

  always_comb begin
    case (rdSel)
      RD_STAT: rdWord = statQ;
      RD_MASK: rdWord = maskQ;
      default: rdWord = '0;
    endcase
    rdData = rdWide ? rdWord : {{(REG_W-HALF_W){1'b0}}, rdWord[HALF_W-1:0]};
  end

  assign irqOut   = irqQ;
  assign chkPulse = chkQ;

  AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statWr |=> ((statQ & $past(reqIn)) == $past(reqIn))); // R2
  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statWr |=> ((statQ & $past(statQ)) == $past(statQ))); // R2
  AST_ACK_NO_NEW: assert property (@(posedge clk) disable iff (!rstN)
    strb.statWr |=> ((statQ & ~($past(statQ) | $past(reqIn))) == '0)); // R3
  AST_ACK_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && strb.hiLane) |=> ((statQ & ~$past(maskQ)) == '0)); // R3
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskWr |=> $stable(maskQ)); // R5
  AST_HALF_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.maskWr || strb.statWr) && !strb.hiLane) |=>
      (maskQ[REG_W-1:HALF_W] == $past(maskQ[REG_W-1:HALF_W]))); // R6
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (|(statQ & maskQ)) |=> irqOut); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statQ & maskQ)) |=> !irqOut); // R7
  AST_CHK_AFTER_MASK: assert property (@(posedge clk) disable iff (!rstN)
    chkPulse |-> $past(strb.maskWr)); // R8
  AST_CHK_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    chkPulse |-> (|(statQ & maskQ))); // R8
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int STAT_OFS = 'h070,
  parameter int MASK_OFS = 'h074
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busWide,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic [REG_W-1:0]  reqIn,
  output logic              irqOut,
  output logic              checkPulse
);
  wrStrobe_t strb;
  rdSel_t    rdSel;
  logic      rdWide;

  irq_ctrl_decode #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) uDecode (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busWide(busWide),
    .strb   (strb),
    .rdSel  (rdSel),
    .rdWide (rdWide)
  );

  irq_ctrl_regs uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .rdWide  (rdWide),
    .wrData  (busWrData),
    .reqIn   (reqIn),
    .rdData  (busRdData),
    .irqOut  (irqOut),
    .chkPulse(checkPulse)
  );
endmodule

// File: tb/irq_stat_ctrl_test.sv
`timescale 1ns/1ps
module irq_stat_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busWide = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] reqIn = '0;
  logic        irqOut;
  logic        checkPulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_stat_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWide(busWide), .busWrData(busWrData), .busRdData(busRdData),
    .reqIn(reqIn), .irqOut(irqOut), .checkPulse(checkPulse)
  );

  localparam logic [11:0] A_STAT = 12'h070;
  localparam logic [11:0] A_MASK = 12'h074;

  typedef struct packed {
    logic        isReq;
    logic [11:0] addr;
    logic        wide;
    logic [31:0] data;
    logic [31:0] expStat;
    logic [31:0] expMask;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h074, 1'b1, 32'h0000_0288, 32'h0000_0000, 32'h0000_0288},
    '{1'b1, 12'h000, 1'b1, 32'h0000_0008, 32'h0000_0008, 32'h0000_0288},
    '{1'b1, 12'h000, 1'b1, 32'h0001_0080, 32'h0001_0088, 32'h0000_0288},
    '{1'b0, 12'h070, 1'b1, 32'hFFFF_FFF7, 32'h0000_0080, 32'h0000_0288},
    '{1'b0, 12'h074, 1'b0, 32'hFFFF_0000, 32'h0000_0080, 32'h0000_0000},
    '{1'b0, 12'h074, 1'b1, 32'hFFFF_FFFF, 32'h0000_0080, 32'hFFFF_FFFF},
    '{1'b1, 12'h000, 1'b1, 32'h0003_0200, 32'h0003_0280, 32'hFFFF_FFFF},
    '{1'b0, 12'h070, 1'b0, 32'h0000_0000, 32'h0003_0000, 32'hFFFF_FFFF},
    '{1'b0, 12'h078, 1'b1, 32'h0000_0000, 32'h0003_0000, 32'hFFFF_FFFF},
    '{1'b0, 12'h070, 1'b1, 32'h0001_0000, 32'h0001_0000, 32'hFFFF_FFFF},
    '{1'b0, 12'h074, 1'b1, 32'h0000_0000, 32'h0001_0000, 32'h0000_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, logic w, output logic [31:0] v);
    busAddr = a; busWide = w; busWrEn = 1'b0;
    #1 v = busRdData;
  endtask

  // Drive at a falling edge; the rising edge in between applies it.
  task automatic cycle(logic we, logic [11:0] a, logic w, logic [31:0] d, logic [31:0] r);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWide = w; busWrData = d; reqIn = r;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; reqIn = '0; busAddr = 12'h000;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(A_STAT, 1'b1, v); check("R1 status after reset", v, 32'h0);
    rd(A_MASK, 1'b1, v); check("R1 mask after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);
    check("R1 check pulse after reset", {31'b0, checkPulse}, 32'h0);
    rstN = 1'b1;

    // Vector table: R2 R3 R5 R6 R10 and R7 level
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isReq) cycle(1'b0, 12'h000, 1'b1, 32'h0, VEC[i].data);
      else              cycle(1'b1, VEC[i].addr, VEC[i].wide, VEC[i].data, 32'h0);
      @(negedge clk);
      rd(A_STAT, 1'b1, v); check("R2/R3/R6/R10 status", v, VEC[i].expStat);
      rd(A_MASK, 1'b1, v); check("R5/R6/R10 mask", v, VEC[i].expMask);
      check("R7 irq level", {31'b0, irqOut}, {31'b0, |(VEC[i].expStat & VEC[i].expMask)});
    end

    // R4: request and acknowledge in the same cycle
    doReset();
    cycle(1'b1, A_MASK, 1'b1, 32'hFFFF_FFFF, 32'h0);
    cycle(1'b1, A_STAT, 1'b1, 32'hFFFF_FFF7, 32'h0000_0008);
    rd(A_STAT, 1'b1, v); check("R4 request acked in same cycle", v, 32'h0);
    cycle(1'b1, A_STAT, 1'b1, 32'hFFFF_FFFF, 32'h0000_0200);
    rd(A_STAT, 1'b1, v); check("R4 request kept by write of one", v, 32'h0000_0200);

    // R7: irq latency, one cycle behind the status register
    doReset();
    cycle(1'b1, A_MASK, 1'b1, 32'hFFFF_FFFF, 32'h0);
    cycle(1'b0, 12'h000, 1'b1, 32'h0, 32'h0000_0008);
    check("R7 irq still low right after set", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R7 irq high one cycle later", {31'b0, irqOut}, 32'h1);

    // R9: read widths and unmapped reads
    cycle(1'b0, 12'h000, 1'b1, 32'h0, 32'h0001_0000);
    rd(A_STAT, 1'b0, v); check("R9 16-bit read zero-extended", v, 32'h0000_0008);
    rd(A_STAT, 1'b1, v); check("R9 32-bit read", v, 32'h0001_0008);
    rd(12'h07C, 1'b1, v); check("R9 unmapped read", v, 32'h0);
    rd(A_MASK, 1'b0, v); check("R9 16-bit mask read", v, 32'h0000_FFFF);

    // R8: check pulse after a mask write
    doReset();
    cycle(1'b0, 12'h000, 1'b1, 32'h0, 32'h0000_0008);
    cycle(1'b1, A_MASK, 1'b1, 32'h0000_0002, 32'h0);
    check("R8 no pulse when nothing enabled pending", {31'b0, checkPulse}, 32'h0);
    cycle(1'b1, A_MASK, 1'b1, 32'h0000_0008, 32'h0);
    check("R8 pulse after enabling pending bit", {31'b0, checkPulse}, 32'h1);
    @(negedge clk);
    check("R8 pulse lasts one cycle", {31'b0, checkPulse}, 32'h0);

    // R1: reset in the middle of activity
    @(negedge clk); rstN = 1'b0;
    #1;
    rd(A_STAT, 1'b1, v); check("R1 status cleared mid-run", v, 32'h0);
    rd(A_MASK, 1'b1, v); check("R1 mask cleared mid-run", v, 32'h0);
    check("R1 irq cleared mid-run", {31'b0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    finishRun();
  end
endmodule